// File: doc/BRIEF.md
# Audio Serial Port Register File

This block is the software-visible control and status bank of a stereo audio serial port. A bus master reaches sixteen 32-bit words through a simple single-cycle bus. The byte address selects the word, with one word every four bytes, and the two low address bits are ignored. Read data is combinational and valid in the cycle the access is presented. Writes take effect on the next clock edge.

The stored fields drive the serializer and clock generator as plain configuration outputs: the enables, the master/slave choice, the per-line output enables, the format words, the clock divider and the channel select and map words. The bank also forwards FIFO traffic. A write to the transmit data word becomes a push strobe with its data. A read of the receive data word returns the FIFO head and pulses a pop strobe. Flush requests become one-cycle pulses. Two sample counters advance on hardware pulses and can be reloaded by software. DMA requests combine a software enable with a fixed FIFO level threshold.

Top module: `audio_port_regs`

## Requirements
- R1: After reset the words read 0x0000000C (byte 0x04), 0x00004020 (0x08), 0x000400F0 (0x14), 0x00000001 (0x30), 0x76543210 (0x34), 0x00000001 (0x38) and 0x00003210 (0x3C). Every other stored word and both counters read 0, and all configuration outputs follow these values.
- R2: The control word at 0x00 drives the outputs as follows: bit 0 drives globalEn, bit 1 drives rxEn, bit 2 drives txEn, bit 5 drives slaveMode (1 = slave, 0 = master), and bits 8 upward drive sdoEn, one bit per data line. Each output changes on the clock edge that ends the write.
- R3: The format words (0x04, 0x08), DMA control (0x1C), interrupt status (0x20), clock divider (0x24) and the four channel words (0x30 to 0x3C) read back exactly what was last written. Each drives its matching output where one exists.
- R4: A write to 0x0C raises txWrStb for that cycle, with txWrData equal to the written data. A read of 0x0C returns 0.
- R5: A read of 0x10 returns rxFifoData and raises rxRdStb in the same cycle. A write to 0x10 changes no state.
- R6: A read of 0x18 returns the receive FIFO level in bits LVL_W-1:0 and the transmit FIFO level in bits 16+LVL_W-1:16, with all other bits 0. A write to 0x18 changes no state.
- R7: Writing 1 to bit 25 of 0x14 raises txFlush, and writing 1 to bit 24 raises rxFlush, each for exactly the one cycle after the write. These bits always read 0. Bit 2 drives txAlign, bits 1:0 drive rxAlign, and the other bits of 0x14 are stored.
- R8: txDrq is 1 exactly when bit 7 of 0x1C is set and the transmit level is below TX_THRESH (default 32). rxDrq is 1 exactly when bit 3 of 0x1C is set and the receive level is at least RX_THRESH (default 8).
- R9: The receive count (0x28) and transmit count (0x2C) each grow by one on every cycle that rxCntInc or txCntInc is high, and a read always returns the live count.
- R10: A software write to a count word loads the written value, so writing 0 clears it. The write wins over a hardware increment in the same cycle.
- R11: Addresses from 0x40 upward read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| txWrStb | output | 1 | Push to the transmit FIFO |
| txWrData | output | 32 | Data for the push |
| rxRdStb | output | 1 | Pop from the receive FIFO |
| rxFifoData | input | 32 | Head of the receive FIFO |
| txFifoLevel | input | LVL_W | Transmit FIFO fill level |
| rxFifoLevel | input | LVL_W | Receive FIFO fill level |
| txCntInc | input | 1 | Transmit sample counter increment |
| rxCntInc | input | 1 | Receive sample counter increment |
| globalEn | output | 1 | Whole-port enable |
| rxEn | output | 1 | Receive path enable |
| txEn | output | 1 | Transmit path enable |
| slaveMode | output | 1 | 1 = clocks from outside |
| sdoEn | output | SDO_N | Per data line output enable |
| fmt0Out | output | 32 | Format word 0 |
| fmt1Out | output | 32 | Format word 1 |
| txAlign | output | 1 | Transmit sample alignment mode |
| rxAlign | output | 2 | Receive sample alignment mode |
| txFlush | output | 1 | One-cycle transmit FIFO flush |
| rxFlush | output | 1 | One-cycle receive FIFO flush |
| clkDivOut | output | 32 | Clock divider word |
| txChanSelOut | output | 32 | Transmit channel select |
| txChanMapOut | output | 32 | Transmit channel map |
| rxChanSelOut | output | 32 | Receive channel select |
| rxChanMapOut | output | 32 | Receive channel map |
| txDrq | output | 1 | Transmit DMA request |
| rxDrq | output | 1 | Receive DMA request |

## Verification
The access rules are tried with reads and writes aimed at every kind of word: plain stored words, the push-only and pop-only data words, the read-only status word, the flush bits and the unmapped range. Writes to read-only and unmapped addresses are followed by comparisons of every output and readback against the model, so a decode that leaks into the wrong register is caught. The counters are driven with runs of increments, then with a software load in the same cycle as an increment, which tells write priority apart from increment priority. The FIFO levels are stepped across each DMA threshold, one below and at the boundary, with the enable both set and clear, which separates an off-by-one compare from a missing enable.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;

  localparam int REG_N = 16;
  localparam int IDX_W = $clog2(REG_N);

  typedef enum logic [IDX_W-1:0] {
    RID_CTRL    = 4'd0,
    RID_FMT0    = 4'd1,
    RID_FMT1    = 4'd2,
    RID_TXDATA  = 4'd3,
    RID_RXDATA  = 4'd4,
    RID_FIFOCTL = 4'd5,
    RID_FIFOSTA = 4'd6,
    RID_DMACTL  = 4'd7,
    RID_INTSTA  = 4'd8,
    RID_CLKDIV  = 4'd9,
    RID_RXCNT   = 4'd10,
    RID_TXCNT   = 4'd11,
    RID_TXSEL   = 4'd12,
    RID_TXMAP   = 4'd13,
    RID_RXSEL   = 4'd14,
    RID_RXMAP   = 4'd15
  } regIdT;

  // Decoded access handed from the decoder to the storage.
  typedef struct packed {
    logic        hit;
    logic        wr;
    logic        rd;
    regIdT       id;
    logic [31:0] data;
  } busStrobeT;

  localparam int TX_FLUSH_BIT = 25;
  localparam int RX_FLUSH_BIT = 24;
  localparam logic [31:0] FLUSH_MASK = (32'd1 << TX_FLUSH_BIT) | (32'd1 << RX_FLUSH_BIT);

  function automatic logic [31:0] resetVal(input int idx);
    case (idx)
      1:       resetVal = 32'h0000_000C;
      2:       resetVal = 32'h0000_4020;
      5:       resetVal = 32'h0004_00F0;
      12:      resetVal = 32'h0000_0001;
      13:      resetVal = 32'h7654_3210;
      14:      resetVal = 32'h0000_0001;
      15:      resetVal = 32'h0000_3210;
      default: resetVal = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/aud_regs_decode.sv
module aud_regs_decode
  import aud_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output busStrobeT         stb
);

  localparam int LOW_W = IDX_W + 2;

  logic  inRange;
  regIdT id;
  logic  writeOk;
  logic  readOk;
  logic  unusedByteBits;

  assign unusedByteBits = ^busAddr[1:0];

  generate
    if (ADDR_W > LOW_W) begin : gUpper
      assign inRange = (busAddr[ADDR_W-1:LOW_W] == '0);
    end else begin : gNoUpper
      assign inRange = 1'b1;
    end
  endgenerate

  assign id = regIdT'(busAddr[LOW_W-1:2]);

  always_comb begin
    writeOk = !((id == RID_RXDATA) || (id == RID_FIFOSTA));
    readOk  = (id != RID_TXDATA);
  end

  always_comb begin
    stb.hit  = busSel && inRange;
    stb.wr   = busSel && inRange && busWr && writeOk;
    stb.rd   = busSel && inRange && !busWr && readOk;
    stb.id   = id;
    stb.data = busWdata;
  end

endmodule

// File: rtl/aud_regs_store.sv
module aud_regs_store
  import aud_regs_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  busStrobeT               stb,
  input  logic [31:0]             rxFifoData,
  input  logic [LVL_W-1:0]        txFifoLevel,
  input  logic [LVL_W-1:0]        rxFifoLevel,
  input  logic                    txCntInc,
  input  logic                    rxCntInc,
  output logic [31:0]             busRdata,
  output logic                    txWrStb,
  output logic [31:0]             txWrData,
  output logic                    rxRdStb,
  output logic                    txFlush,
  output logic                    rxFlush,
  output logic [REG_N-1:0][31:0]  regView
);

  logic [31:0] statusWord;
  logic        fifoCtlWr;

  always_comb begin
    statusWord                 = '0;
    statusWord[LVL_W-1:0]      = rxFifoLevel;
    statusWord[16 +: LVL_W]    = txFifoLevel;
  end

  generate
    for (genvar gi = 0; gi < REG_N; gi++) begin : gReg
      localparam regIdT MY_ID = regIdT'(gi);
      logic wrHit;
      assign wrHit = stb.wr && (stb.id == MY_ID);

      if (MY_ID == RID_TXDATA) begin : gPush
        assign regView[gi] = '0;
      end else if (MY_ID == RID_RXDATA) begin : gPop
        assign regView[gi] = rxFifoData;
      end else if (MY_ID == RID_FIFOSTA) begin : gStatus
        assign regView[gi] = statusWord;
      end else if ((MY_ID == RID_RXCNT) || (MY_ID == RID_TXCNT)) begin : gCount
        logic [31:0] cntQ;
        logic        bump;
        assign bump = (MY_ID == RID_RXCNT) ? rxCntInc : txCntInc;
        always_ff @(posedge clk) begin
          if (rst)        cntQ <= '0;
          else if (wrHit) cntQ <= stb.data;
          else if (bump)  cntQ <= cntQ + 32'd1;
        end
        assign regView[gi] = cntQ;
      end else if (MY_ID == RID_FIFOCTL) begin : gFifoCtl
        logic [31:0] q;
        always_ff @(posedge clk) begin
          if (rst)        q <= resetVal(gi);
          else if (wrHit) q <= stb.data & ~FLUSH_MASK;
        end
        assign regView[gi] = q;
      end else begin : gPlain
        logic [31:0] q;
        always_ff @(posedge clk) begin
          if (rst)        q <= resetVal(gi);
          else if (wrHit) q <= stb.data;
        end
        assign regView[gi] = q;
      end
    end
  endgenerate

  assign fifoCtlWr = stb.wr && (stb.id == RID_FIFOCTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      txFlush <= 1'b0;
      rxFlush <= 1'b0;
    end else begin
      txFlush <= fifoCtlWr && stb.data[TX_FLUSH_BIT];
      rxFlush <= fifoCtlWr && stb.data[RX_FLUSH_BIT];
    end
  end

  assign busRdata = stb.rd ? regView[stb.id] : '0;
  assign txWrStb  = stb.wr && (stb.id == RID_TXDATA);
  assign txWrData = stb.data;
  assign rxRdStb  = stb.rd && (stb.id == RID_RXDATA);

endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import aud_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LVL_W     = 7,
  parameter int SDO_N     = 4,
  parameter int TX_THRESH = 32,
  parameter int RX_THRESH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txWrStb,
  output logic [31:0]       txWrData,
  output logic              rxRdStb,
  input  logic [31:0]       rxFifoData,
  input  logic [LVL_W-1:0]  txFifoLevel,
  input  logic [LVL_W-1:0]  rxFifoLevel,
  input  logic              txCntInc,
  input  logic              rxCntInc,
  output logic              globalEn,
  output logic              rxEn,
  output logic              txEn,
  output logic              slaveMode,
  output logic [SDO_N-1:0]  sdoEn,
  output logic [31:0]       fmt0Out,
  output logic [31:0]       fmt1Out,
  output logic              txAlign,
  output logic [1:0]        rxAlign,
  output logic              txFlush,
  output logic              rxFlush,
  output logic [31:0]       clkDivOut,
  output logic [31:0]       txChanSelOut,
  output logic [31:0]       txChanMapOut,
  output logic [31:0]       rxChanSelOut,
  output logic [31:0]       rxChanMapOut,
  output logic              txDrq,
  output logic              rxDrq
);

  localparam logic [LVL_W:0] TX_LIM = (LVL_W+1)'(TX_THRESH);
  localparam logic [LVL_W:0] RX_LIM = (LVL_W+1)'(RX_THRESH);

  busStrobeT              stb;
  logic [REG_N-1:0][31:0] regView;
  logic                   unusedCfg;

  aud_regs_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  aud_regs_store #(.LVL_W(LVL_W)) uStore (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .rxFifoData  (rxFifoData),
    .txFifoLevel (txFifoLevel),
    .rxFifoLevel (rxFifoLevel),
    .txCntInc    (txCntInc),
    .rxCntInc    (rxCntInc),
    .busRdata    (busRdata),
    .txWrStb     (txWrStb),
    .txWrData    (txWrData),
    .rxRdStb     (rxRdStb),
    .txFlush     (txFlush),
    .rxFlush     (rxFlush),
    .regView     (regView)
  );

  assign globalEn     = regView[RID_CTRL][0];
  assign rxEn         = regView[RID_CTRL][1];
  assign txEn         = regView[RID_CTRL][2];
  assign slaveMode    = regView[RID_CTRL][5];
  assign sdoEn        = regView[RID_CTRL][8 +: SDO_N];
  assign fmt0Out      = regView[RID_FMT0];
  assign fmt1Out      = regView[RID_FMT1];
  assign txAlign      = regView[RID_FIFOCTL][2];
  assign rxAlign      = regView[RID_FIFOCTL][1:0];
  assign clkDivOut    = regView[RID_CLKDIV];
  assign txChanSelOut = regView[RID_TXSEL];
  assign txChanMapOut = regView[RID_TXMAP];
  assign rxChanSelOut = regView[RID_RXSEL];
  assign rxChanMapOut = regView[RID_RXMAP];

  assign txDrq = regView[RID_DMACTL][7] && ({1'b0, txFifoLevel} < TX_LIM);
  assign rxDrq = regView[RID_DMACTL][3] && ({1'b0, rxFifoLevel} >= RX_LIM);

  assign unusedCfg = ^{regView[RID_CTRL], regView[RID_FIFOCTL], regView[RID_DMACTL],
                       regView[RID_INTSTA], regView[RID_TXDATA], regView[RID_RXDATA],
                       regView[RID_FIFOSTA], regView[RID_RXCNT], regView[RID_TXCNT]};

endmodule

// File: rtl/aud_regs_checker.sv
module aud_regs_checker #(
  parameter int ADDR_W    = 8,
  parameter int LVL_W     = 7,
  parameter int TX_THRESH = 32,
  parameter int RX_THRESH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [LVL_W-1:0]  txFifoLevel,
  input logic [LVL_W-1:0]  rxFifoLevel,
  input logic              globalEn,
  input logic [31:0]       fmt0Out,
  input logic [31:0]       clkDivOut,
  input logic [31:0]       txChanMapOut,
  input logic              txFlush,
  input logic              rxFlush,
  input logic              txDrq,
  input logic              rxDrq
);

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!globalEn && fmt0Out == 32'h0000_000C && txChanMapOut == 32'h7654_3210))
    else $error("reset values wrong");

  assert_txdata_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWr && busAddr == ADDR_W'(12)) |-> (busRdata == 32'h0))
    else $error("tx data word readable");

  assert_rxdata_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWr && busAddr == ADDR_W'(16)) |=> $stable({globalEn, fmt0Out, clkDivOut, txChanMapOut}))
    else $error("write to rx data word changed state");

  assert_tx_flush_cause_R7: assert property (@(posedge clk) disable iff (rst)
    txFlush |-> $past(busSel && busWr && busAddr == ADDR_W'(20) && busWdata[25]))
    else $error("tx flush without request");

  assert_rx_flush_cause_R7: assert property (@(posedge clk) disable iff (rst)
    rxFlush |-> $past(busSel && busWr && busAddr == ADDR_W'(20) && busWdata[24]))
    else $error("rx flush without request");

  assert_tx_drq_level_R8: assert property (@(posedge clk) disable iff (rst)
    txDrq |-> (int'(txFifoLevel) < TX_THRESH))
    else $error("tx request above threshold");

  assert_rx_drq_level_R8: assert property (@(posedge clk) disable iff (rst)
    rxDrq |-> (int'(rxFifoLevel) >= RX_THRESH))
    else $error("rx request below threshold");

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWr && busAddr >= ADDR_W'(64)) |-> (busRdata == 32'h0))
    else $error("unmapped read nonzero");

endmodule

bind audio_port_regs aud_regs_checker #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .TX_THRESH(TX_THRESH), .RX_THRESH(RX_THRESH)
) uChecker (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .txFifoLevel(txFifoLevel),
  .rxFifoLevel(rxFifoLevel), .globalEn(globalEn), .fmt0Out(fmt0Out),
  .clkDivOut(clkDivOut), .txChanMapOut(txChanMapOut), .txFlush(txFlush),
  .rxFlush(rxFlush), .txDrq(txDrq), .rxDrq(rxDrq)
);

// File: tb/tb_audio_port_regs.sv
module tb_audio_port_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txWrStb;
  logic [31:0] txWrData;
  logic        rxRdStb;
  logic [31:0] rxFifoData = '0;
  logic [6:0]  txFifoLevel = '0;
  logic [6:0]  rxFifoLevel = '0;
  logic        txCntInc = 1'b0;
  logic        rxCntInc = 1'b0;
  logic        globalEn, rxEn, txEn, slaveMode;
  logic [3:0]  sdoEn;
  logic [31:0] fmt0Out, fmt1Out, clkDivOut;
  logic        txAlign;
  logic [1:0]  rxAlign;
  logic        txFlush, rxFlush;
  logic [31:0] txChanSelOut, txChanMapOut, rxChanSelOut, rxChanMapOut;
  logic        txDrq, rxDrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  audio_port_regs dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txWrStb(txWrStb), .txWrData(txWrData),
    .rxRdStb(rxRdStb), .rxFifoData(rxFifoData), .txFifoLevel(txFifoLevel),
    .rxFifoLevel(rxFifoLevel), .txCntInc(txCntInc), .rxCntInc(rxCntInc),
    .globalEn(globalEn), .rxEn(rxEn), .txEn(txEn), .slaveMode(slaveMode),
    .sdoEn(sdoEn), .fmt0Out(fmt0Out), .fmt1Out(fmt1Out), .txAlign(txAlign),
    .rxAlign(rxAlign), .txFlush(txFlush), .rxFlush(rxFlush), .clkDivOut(clkDivOut),
    .txChanSelOut(txChanSelOut), .txChanMapOut(txChanMapOut),
    .rxChanSelOut(rxChanSelOut), .rxChanMapOut(rxChanMapOut),
    .txDrq(txDrq), .rxDrq(rxDrq)
  );

  // Behavioural reference model
  logic [31:0] mReg [16];
  logic [31:0] mTxCnt, mRxCnt;
  logic        mTxF, mRxF;

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mReg[i] = 32'h0;
    mReg[1]  = 32'h0000_000C;
    mReg[2]  = 32'h0000_4020;
    mReg[5]  = 32'h0004_00F0;
    mReg[12] = 32'h1;
    mReg[13] = 32'h7654_3210;
    mReg[14] = 32'h1;
    mReg[15] = 32'h0000_3210;
    mTxCnt = 0; mRxCnt = 0; mTxF = 0; mRxF = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (rst) begin
      modelReset();
    end else begin
      bit txW, rxW;
      txW = 0; rxW = 0;
      mTxF = 0; mRxF = 0;
      if (busSel && busWr && busAddr < 8'd64) begin
        case (busAddr >> 2)
          3, 4, 6: ;
          5: begin
            mReg[5] = busWdata & ~32'h0300_0000;
            mTxF = busWdata[25];
            mRxF = busWdata[24];
          end
          10: begin mRxCnt = busWdata; rxW = 1; end
          11: begin mTxCnt = busWdata; txW = 1; end
          default: mReg[busAddr >> 2] = busWdata;
        endcase
      end
      if (rxCntInc && !rxW) mRxCnt = mRxCnt + 1;
      if (txCntInc && !txW) mTxCnt = mTxCnt + 1;
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a >= 8'd64) return 32'h0;
    case (a >> 2)
      3:  return 32'h0;
      4:  return rxFifoData;
      6:  return {9'h0, txFifoLevel, 9'h0, rxFifoLevel};
      10: return mRxCnt;
      11: return mTxCnt;
      default: return mReg[a >> 2];
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of every configuration output against the model
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      check("R2 control fields", {28'h0, globalEn, rxEn, txEn, slaveMode},
            {28'h0, mReg[0][0], mReg[0][1], mReg[0][2], mReg[0][5]});
      check("R2 sdoEn", {28'h0, sdoEn}, {28'h0, mReg[0][11:8]});
      check("R3 fmt0", fmt0Out, mReg[1]);
      check("R3 fmt1", fmt1Out, mReg[2]);
      check("R3 clkdiv", clkDivOut, mReg[9]);
      check("R3 channel words", txChanSelOut ^ {txChanMapOut[15:0], txChanMapOut[31:16]} ^ rxChanSelOut ^ ~rxChanMapOut,
            mReg[12] ^ {mReg[13][15:0], mReg[13][31:16]} ^ mReg[14] ^ ~mReg[15]);
      check("R7 flush pulses", {30'h0, txFlush, rxFlush}, {30'h0, mTxF, mRxF});
      check("R7 align", {29'h0, txAlign, rxAlign}, {29'h0, mReg[5][2], mReg[5][1:0]});
      check("R8 drq", {30'h0, txDrq, rxDrq},
            {30'h0, mReg[7][7] && (txFifoLevel < 7'd32), mReg[7][3] && (rxFifoLevel >= 7'd8)});
      check("R4 push strobe", {31'h0, txWrStb}, {31'h0, busSel && busWr && busAddr == 8'd12});
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    #1;
    if (a == 8'd12) begin
      check("R4 push strobe on write", {31'h0, txWrStb}, 32'h1);
      check("R4 push data", txWrData, d);
    end
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input string tag, input logic [7:0] a, input bit useModel,
                         input logic [31:0] exp);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #2;
    check(tag, busRdata, useModel ? expRead(a) : exp);
    if (a == 8'd16) check("R5 pop strobe", {31'h0, rxRdStb}, 32'h1);
    @(negedge clk);
    busSel = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state
    busRead("R1 ctrl", 8'h00, 0, 32'h0);
    busRead("R1 fmt0", 8'h04, 0, 32'h0000_000C);
    busRead("R1 fmt1", 8'h08, 0, 32'h0000_4020);
    busRead("R1 fifoctl", 8'h14, 0, 32'h0004_00F0);
    busRead("R1 dmactl", 8'h1C, 0, 32'h0);
    busRead("R1 txsel", 8'h30, 0, 32'h1);
    busRead("R1 txmap", 8'h34, 0, 32'h7654_3210);
    busRead("R1 rxsel", 8'h38, 0, 32'h1);
    busRead("R1 rxmap", 8'h3C, 0, 32'h0000_3210);
    busRead("R1 rxcount", 8'h28, 0, 32'h0);
    busRead("R1 txcount", 8'h2C, 0, 32'h0);

    // R2: control fields
    busWrite(8'h00, 32'h0000_0F27);
    #1;
    check("R2 enables slave", {28'h0, globalEn, rxEn, txEn, slaveMode}, 32'hF);
    check("R2 sdo lines", {28'h0, sdoEn}, 32'hF);
    busWrite(8'h00, 32'h0000_0201);
    #1;
    check("R2 master one line", {24'h0, globalEn, rxEn, txEn, slaveMode, sdoEn}, 32'h82);

    // R3: plain readback
    busWrite(8'h04, 32'hA5A5_0F13);
    busWrite(8'h08, 32'h1234_ABCD);
    busWrite(8'h20, 32'hDEAD_0001);
    busWrite(8'h24, 32'h0000_00B2);
    busWrite(8'h30, 32'h0000_0003);
    busWrite(8'h34, 32'h0123_4567);
    busWrite(8'h38, 32'h0000_0007);
    busWrite(8'h3C, 32'h0000_1032);
    busRead("R3 fmt0", 8'h04, 0, 32'hA5A5_0F13);
    busRead("R3 fmt1", 8'h08, 0, 32'h1234_ABCD);
    busRead("R3 intsta", 8'h20, 0, 32'hDEAD_0001);
    busRead("R3 clkdiv", 8'h24, 0, 32'h0000_00B2);
    busRead("R3 txmap", 8'h34, 0, 32'h0123_4567);
    busRead("R3 rxmap", 8'h3C, 0, 32'h0000_1032);

    // R4: push-only word
    busWrite(8'h0C, 32'hCAFE_BABE);
    busRead("R4 tx word reads zero", 8'h0C, 0, 32'h0);

    // R5: pop-only word
    rxFifoData = 32'h1357_9BDF;
    busRead("R5 rx word", 8'h10, 0, 32'h1357_9BDF);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busRead("R5 write ignored fmt0", 8'h04, 0, 32'hA5A5_0F13);
    busRead("R5 write ignored ctrl", 8'h00, 0, 32'h0000_0201);

    // R6: status word
    rxFifoLevel = 7'd5; txFifoLevel = 7'd40;
    busRead("R6 status", 8'h18, 0, 32'h0028_0005);
    busWrite(8'h18, 32'h0000_FFFF);
    busRead("R6 status after write", 8'h18, 0, 32'h0028_0005);

    // R7: flush pulses and alignment
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 8'h14; busWdata = 32'h0300_0005;
    @(negedge clk);
    busSel = 0; busWr = 0;
    #1;
    check("R7 flush high one cycle", {30'h0, txFlush, rxFlush}, 32'h3);
    @(negedge clk);
    #1;
    check("R7 flush dropped", {30'h0, txFlush, rxFlush}, 32'h0);
    busRead("R7 flush bits read zero", 8'h14, 0, 32'h0000_0005);
    check("R7 align outputs", {29'h0, txAlign, rxAlign}, 32'h5);
    busWrite(8'h14, 32'h0100_0000);
    #1;
    check("R7 rx flush only", {30'h0, txFlush, rxFlush}, 32'h1);

    // R8: DMA requests around thresholds
    busWrite(8'h1C, 32'h0000_0088);
    @(negedge clk); txFifoLevel = 7'd31; rxFifoLevel = 7'd7; #1;
    check("R8 tx below, rx below", {30'h0, txDrq, rxDrq}, 32'h2);
    @(negedge clk); txFifoLevel = 7'd32; rxFifoLevel = 7'd8; #1;
    check("R8 tx at, rx at", {30'h0, txDrq, rxDrq}, 32'h1);
    busWrite(8'h1C, 32'h0000_0000);
    @(negedge clk); txFifoLevel = 7'd0; rxFifoLevel = 7'd60; #1;
    check("R8 disabled", {30'h0, txDrq, rxDrq}, 32'h0);

    // R9: counters
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rxCntInc = 1; txCntInc = (i < 3);
    end
    @(negedge clk); rxCntInc = 0; txCntInc = 0;
    busRead("R9 rx count", 8'h28, 0, 32'd5);
    busRead("R9 tx count", 8'h2C, 0, 32'd3);

    // R10: software load beats increment
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 8'h2C; busWdata = 32'h0; txCntInc = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; txCntInc = 0;
    busRead("R10 tx cleared", 8'h2C, 0, 32'h0);
    busWrite(8'h28, 32'h0000_0100);
    @(negedge clk); rxCntInc = 1;
    @(negedge clk); rxCntInc = 0;
    busRead("R10 rx loaded then counted", 8'h28, 0, 32'h0000_0101);
    busRead("R9 rx count model", 8'h28, 1, 32'h0);

    // R11: unmapped range
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'hFC, 32'h1234_5678);
    busRead("R11 read 0x40", 8'h40, 0, 32'h0);
    busRead("R11 read 0xFC", 8'hFC, 0, 32'h0);
    busRead("R11 ctrl intact", 8'h00, 1, 32'h0);
    busRead("R11 clkdiv intact", 8'h24, 0, 32'h0000_00B2);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule